// File: doc/BRIEF.md
# Limit-Compare Interval Timer Bank

This block holds a small bank of interval timers: one system-wide timer plus one timer per processor, for one to four processors. A prescaler turns the system clock into a one-microsecond tick. On every tick each timer advances its counter. When the counter arrives at its programmed limit, the counter goes back to 1 and the timer's interrupt flag is set. The system timer's flag drives the level-10 interrupt line. Each processor timer's flag drives the level-14 line of its own processor.

Software reaches the timers through a word-addressed register port. An address is made of a timer index in the upper bits and a word offset in the low three bits. Index `NUM_CPUS` selects the system timer. Lower indices select the processor timers.

Limits and counts sit in bits 30:10 of the data word, so a period of P ticks is loaded as (P+1)<<10. The interrupt is acknowledged as a side effect of reading the limit word. A second alias of the limit word returns the same value but leaves the flag alone. Read data comes back one cycle after the read strobe.

Top module: `ivt_bank`

## Requirements
- R1: After reset, all interrupt outputs are low, every limit field reads 0 and the configuration word reads 0.
- R2: The prescaler produces one tick every `TICK_DIV` clock cycles, and every counter advances by exactly one per tick.
- R3: A limit write at offset 0 stores data bits 30:10 as the limit field and discards bits 31 and 9:0. A read at offset 0 or offset 2 returns the pending flag in bit 31, the limit field in bits 30:10 and zeros in bits 9:0.
- R4: With a limit field L of 2 or more, the tick that would carry the counter to L instead reloads it with 1 and sets the pending flag. Pending flags therefore recur every L-1 ticks.
- R5: A read at offset 0 returns bit 31 as it was before the read, then clears that timer's pending flag. If a limit hit falls in the same cycle, the flag stays set.
- R6: A read at offset 2 returns the same word as offset 0 and leaves the pending flag unchanged.
- R7: A read at offset 1 returns the pending flag in bit 31 and the counter in bits 30:10, with no side effect. Writes to offset 1 change neither the counter nor the limit.
- R8: A write at offset 0 or offset 2 loads the limit, reloads the counter with 1 and clears the pending flag in the same cycle.
- R9: With a limit field of 0, the counter increments on every tick and never sets the pending flag.
- R10: The system timer's flag appears only on `irqSys`. The flag of processor timer i appears only on `irqCpu[i]`.
- R11: On the system timer, offset 4 is a configuration word: the low `NUM_CPUS` bits are writable and the upper bits read 0. Offset 3 of any timer, offset 4 of a processor timer and any index above `NUM_CPUS` read 0 and ignore writes.
- R12: `regRvalid` is high in exactly the cycle after each cycle in which `regRd` is high, and `regRdata` is valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | IDX_W+3 | Timer index in the upper bits, word offset in bits 2:0 |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, registered |
| regRvalid | output | 1 | Read data valid, one cycle after `regRd` |
| irqSys | output | 1 | Level-10 interrupt from the system timer |
| irqCpu | output | NUM_CPUS | Level-14 interrupt, one per processor timer |

## Verification
The hardest case to reach from the ports is an acknowledging read that lands in the same clock cycle as a new limit hit. The flag must survive that collision. The bench cannot see the prescaler phase. Instead it waits for a rising interrupt, which marks a hit edge. It then counts exactly one period of clock cycles before issuing the offset-0 read, so the read strikes the next hit. Other checks are also placed relative to a limit write, not to reset. Each tick count in those checks spans a whole multiple of the prescaler ratio, which makes the expected counter value exact whatever the phase.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

  // Limit and count fields live in bits 30:10 of a register word.
  localparam int LIM_LSB = 10;
  localparam int FIELD_W = 21;

  typedef enum logic [2:0] {
    OFF_LIMIT  = 3'd0,
    OFF_COUNT  = 3'd1,
    OFF_PEEK   = 3'd2,
    OFF_RSVD   = 3'd3,
    OFF_CONFIG = 3'd4
  } regOff_e;

  // Shared strobes from control to datapath.
  typedef struct packed {
    logic    tick;
    logic    wrCfg;
    logic    rdStb;
    regOff_e rdOff;
  } ctrlStrb_t;

  // Per-timer commands.
  typedef struct packed {
    logic loadLimit;
    logic ackRead;
  } tmrCmd_t;

endpackage

// File: rtl/ivt_unit.sv
module ivt_unit
  import ivt_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  tmrCmd_t            cmd,
  input  logic [FIELD_W-1:0] limitIn,
  output logic [FIELD_W-1:0] limitQ,
  output logic [FIELD_W-1:0] cntQ,
  output logic               pendQ
);

  logic [FIELD_W:0] cntNext;
  logic             hit;

  assign cntNext = {1'b0, cntQ} + (FIELD_W+1)'(1);
  assign hit     = tick && (limitQ != '0) && (cntNext >= {1'b0, limitQ});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      limitQ <= '0;
      cntQ   <= FIELD_W'(1);
      pendQ  <= 1'b0;
    end else if (cmd.loadLimit) begin
      limitQ <= limitIn;
      cntQ   <= FIELD_W'(1);
      pendQ  <= 1'b0;
    end else begin
      if (hit) begin
        cntQ <= FIELD_W'(1);
      end else if (tick) begin
        cntQ <= cntNext[FIELD_W-1:0];
      end
      // a new hit outranks an acknowledge in the same cycle
      if (hit) begin
        pendQ <= 1'b1;
      end else if (cmd.ackRead) begin
        pendQ <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ivt_ctrl.sv
module ivt_ctrl
  import ivt_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int TICK_DIV = 50,
  parameter int IDX_W    = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [IDX_W+2:0]     regAddr,
  input  logic                 regWr,
  input  logic                 regRd,
  output ctrlStrb_t            strb,
  output tmrCmd_t [NUM_CPUS:0] cmdVec,
  output logic [IDX_W-1:0]     rdIdx
);

  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [PRE_W-1:0] preCnt;
  logic             preWrap;
  logic [IDX_W-1:0] idx;
  regOff_e          off;

  assign preWrap = (preCnt == PRE_W'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (preWrap) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end

  assign idx = regAddr[IDX_W+2:3];
  assign off = regOff_e'(regAddr[2:0]);

  for (genvar t = 0; t <= NUM_CPUS; t++) begin : g_cmd
    logic sel;
    assign sel = (idx == IDX_W'(t));
    assign cmdVec[t].loadLimit = regWr && sel && (off == OFF_LIMIT || off == OFF_PEEK);
    assign cmdVec[t].ackRead   = regRd && sel && (off == OFF_LIMIT);
  end

  assign strb.tick  = preWrap;
  assign strb.wrCfg = regWr && (idx == IDX_W'(NUM_CPUS)) && (off == OFF_CONFIG);
  assign strb.rdStb = regRd;
  assign strb.rdOff = off;
  assign rdIdx      = idx;

endmodule

// File: rtl/ivt_datapath.sv
module ivt_datapath
  import ivt_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int IDX_W    = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrb_t            strb,
  input  tmrCmd_t [NUM_CPUS:0] cmdVec,
  input  logic [IDX_W-1:0]     rdIdx,
  input  logic [31:0]          wrData,
  output logic [31:0]          rdData,
  output logic                 rdValid,
  output logic [NUM_CPUS:0]    pendVec
);

  localparam int NT = NUM_CPUS + 1;

  logic [FIELD_W-1:0] limitArr [NT];
  logic [FIELD_W-1:0] cntArr   [NT];
  logic [NUM_CPUS-1:0] cfgQ;
  logic [FIELD_W-1:0] limitIn;
  logic [31:0]        rdNext;
  logic               unusedWr;

  assign limitIn  = wrData[LIM_LSB +: FIELD_W];
  assign unusedWr = ^{wrData[31], wrData[LIM_LSB-1:NUM_CPUS]};

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    ivt_unit u_tmr (
      .clk     (clk),
      .rstN    (rstN),
      .tick    (strb.tick),
      .cmd     (cmdVec[t]),
      .limitIn (limitIn),
      .limitQ  (limitArr[t]),
      .cntQ    (cntArr[t]),
      .pendQ   (pendVec[t])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (strb.wrCfg) begin
      cfgQ <= wrData[NUM_CPUS-1:0];
    end
  end

  always_comb begin
    rdNext = '0;
    if (int'(rdIdx) < NT) begin
      case (strb.rdOff)
        OFF_LIMIT, OFF_PEEK: rdNext = {pendVec[rdIdx], limitArr[rdIdx], LIM_LSB'(0)};
        OFF_COUNT:           rdNext = {pendVec[rdIdx], cntArr[rdIdx], LIM_LSB'(0)};
        OFF_CONFIG: begin
          if (int'(rdIdx) == NUM_CPUS) rdNext = {{(32-NUM_CPUS){1'b0}}, cfgQ};
        end
        default:             rdNext = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strb.rdStb;
      if (strb.rdStb) rdData <= rdNext;
    end
  end

endmodule

// File: rtl/ivt_bank.sv
module ivt_bank
  import ivt_pkg::*;
#(
  parameter  int NUM_CPUS = 4,
  parameter  int TICK_DIV = 50,
  localparam int IDX_W    = $clog2(NUM_CPUS + 1),
  localparam int ADDR_W   = IDX_W + 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWr,
  input  logic                regRd,
  input  logic [31:0]         regWdata,
  output logic [31:0]         regRdata,
  output logic                regRvalid,
  output logic                irqSys,
  output logic [NUM_CPUS-1:0] irqCpu
);

  ctrlStrb_t            strb;
  tmrCmd_t [NUM_CPUS:0] cmdVec;
  logic [IDX_W-1:0]     rdIdx;
  logic [NUM_CPUS:0]    pendVec;

  ivt_ctrl #(
    .NUM_CPUS (NUM_CPUS),
    .TICK_DIV (TICK_DIV),
    .IDX_W    (IDX_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWr   (regWr),
    .regRd   (regRd),
    .strb    (strb),
    .cmdVec  (cmdVec),
    .rdIdx   (rdIdx)
  );

  ivt_datapath #(
    .NUM_CPUS (NUM_CPUS),
    .IDX_W    (IDX_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .cmdVec  (cmdVec),
    .rdIdx   (rdIdx),
    .wrData  (regWdata),
    .rdData  (regRdata),
    .rdValid (regRvalid),
    .pendVec (pendVec)
  );

  assign irqSys = pendVec[NUM_CPUS];
  assign irqCpu = pendVec[NUM_CPUS-1:0];

endmodule

// File: rtl/ivt_bank_chk.sv
module ivt_bank_chk #(
  parameter int NUM_CPUS = 4,
  parameter int ADDR_W   = 6
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   regAddr,
  input logic                regWr,
  input logic                regRd,
  input logic                regRvalid,
  input logic                irqSys,
  input logic [NUM_CPUS-1:0] irqCpu
);

  logic [2:0]        off;
  logic [ADDR_W-4:0] idx;
  logic              sysLoad;

  assign off     = regAddr[2:0];
  assign idx     = regAddr[ADDR_W-1:3];
  assign sysLoad = regWr && (int'(idx) == NUM_CPUS) && (off == 3'd0 || off == 3'd2);

  always @(posedge clk) begin
    if (!rstN) begin
      AST_RESET_QUIET: assert (irqSys == 1'b0 && irqCpu == '0 && regRvalid == 1'b0); // R1
    end
  end

  AST_RD_VALID_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    regRd |=> regRvalid); // R12

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !regRd |=> !regRvalid); // R12

  AST_SYS_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    sysLoad |=> !irqSys); // R8

  AST_SYS_PEEK_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && int'(idx) == NUM_CPUS && off == 3'd2 && irqSys && !sysLoad) |=> irqSys); // R6

  AST_SYS_RISE_NOT_ON_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqSys) |-> !$past(sysLoad)); // R8

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic cpuLoad;
    assign cpuLoad = regWr && (int'(idx) == c) && (off == 3'd0 || off == 3'd2);
    AST_CPU_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      cpuLoad |=> !irqCpu[c]); // R8
  end

endmodule

bind ivt_bank ivt_bank_chk #(
  .NUM_CPUS (NUM_CPUS),
  .ADDR_W   (ADDR_W)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWr     (regWr),
  .regRd     (regRd),
  .regRvalid (regRvalid),
  .irqSys    (irqSys),
  .irqCpu    (irqCpu)
);

// File: tb/ivt_bank_tb_top.sv
module ivt_bank_tb_top;

  localparam int NC = 4;
  localparam int TD = 4;
  localparam int AW = 6;
  localparam int SYS = NC;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] regAddr;
  logic          regWr, regRd;
  logic [31:0]   regWdata;
  logic [31:0]   regRdata;
  logic          regRvalid;
  logic          irqSys;
  logic [NC-1:0] irqCpu;

  int nChecks = 0;
  int nFails = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ivt_bank #(.NUM_CPUS(NC), .TICK_DIV(TD)) dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWr     (regWr),
    .regRd     (regRd),
    .regWdata  (regWdata),
    .regRdata  (regRdata),
    .regRvalid (regRvalid),
    .irqSys    (irqSys),
    .irqCpu    (irqCpu)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] ad(input int idx, input int off);
    return AW'((idx << 3) | off);
  endfunction

  // driver: one-cycle write, starting at a falling edge
  task automatic wrReg(input int idx, input int off, input logic [31:0] data);
    regAddr = ad(idx, off); regWdata = data; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  // driver: one-cycle read, expected word goes to the scoreboard
  task automatic rdReg(input int idx, input int off, input logic [31:0] exp, input string tag);
    expQ.push_back(exp); tagQ.push_back(tag);
    regAddr = ad(idx, off); regRd = 1'b1;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  function automatic logic irqOf(input int which);
    return (which == SYS) ? irqSys : irqCpu[which];
  endfunction

  task automatic waitHigh(input int which, input string tag);
    int n = 0;
    while (!irqOf(which) && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 2000) chk({tag, " interrupt never rose"}, 32'd0, 32'd1);
  endtask

  // monitor: compares read data against the scoreboard
  always @(negedge clk) begin
    if (rstN && regRvalid) begin
      if (expQ.size() == 0) begin
        chk("R12 read data without a read", 32'd1, 32'd0);
      end else begin
        logic [31:0] e;
        string       t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(t, regRdata, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk("watchdog expired", 32'd1, 32'd0);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    int t0;
    bit seen;
    regAddr = '0; regWr = 1'b0; regRd = 1'b0; regWdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 irq lines low in reset", {27'd0, irqSys, irqCpu}, 32'd0);
    chk("R1 R12 no read valid in reset", {31'd0, regRvalid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    rdReg(0, 0, 32'h0, "R1 cpu0 limit after reset");
    rdReg(SYS, 2, 32'h0, "R1 system limit alias after reset");
    rdReg(SYS, 4, 32'h0, "R1 config after reset");

    // period on processor timer 0, limit field 6 -> every 5 ticks
    wrReg(0, 0, 32'(6) << 10);
    waitHigh(0, "R4");
    t0 = cyc;
    rdReg(0, 1, 32'h8000_0400, "R4 R7 count reloaded to 1 with flag");
    rdReg(0, 2, 32'h8000_1800, "R6 alias read returns limit and flag");
    chk("R6 alias read keeps pending", {31'd0, irqCpu[0]}, 32'd1);
    rdReg(0, 0, 32'h8000_1800, "R5 acknowledging read returns flag");
    chk("R5 acknowledging read clears pending", {31'd0, irqCpu[0]}, 32'd0);
    chk("R10 other lines quiet", {27'd0, irqSys, irqCpu[NC-1:1], 1'b0}, 32'd0);
    waitHigh(0, "R4");
    chk("R4 R2 period is (L-1)*TICK_DIV cycles", 32'(cyc - t0), 32'((6 - 1) * TD));
    wrReg(0, 0, 32'h0);
    chk("R8 limit write clears pending", {31'd0, irqCpu[0]}, 32'd0);

    // system timer, limit field 3 -> every 2 ticks; ack lands on a hit
    wrReg(SYS, 0, 32'(3) << 10);
    waitHigh(SYS, "R4");
    repeat (2 * TD - 1) @(negedge clk);
    rdReg(SYS, 0, 32'h8000_0C00, "R5 colliding read returns flag");
    chk("R5 hit outranks acknowledge", {31'd0, irqSys}, 32'd1);
    chk("R10 processor lines quiet for system hit", {28'd0, irqCpu}, 32'd0);
    wrReg(SYS, 2, 32'h0);
    chk("R8 alias write clears pending", {31'd0, irqSys}, 32'd0);
    rdReg(SYS, 0, 32'h0, "R8 alias write loads limit");

    // field placement
    wrReg(1, 0, 32'hFFFF_FFFF);
    rdReg(1, 0, 32'h7FFF_FC00, "R3 limit field bits 30:10");
    rdReg(1, 2, 32'h7FFF_FC00, "R3 alias matches limit");
    wrReg(1, 0, 32'h8000_03FF);
    rdReg(1, 0, 32'h0, "R3 bits 31 and 9:0 discarded");

    // count register
    wrReg(2, 0, 32'(100) << 10);
    rdReg(2, 1, 32'h0000_0400, "R8 counter reloaded to 1");
    wrReg(2, 0, 32'(100) << 10);
    wrReg(2, 1, 32'h0);
    repeat (39) @(negedge clk);
    rdReg(2, 1, 32'(11) << 10, "R7 R2 write to count ignored, 10 ticks in 40 cycles");
    rdReg(2, 0, 32'(100) << 10, "R7 write to count leaves limit");

    // free-running timer
    wrReg(3, 0, 32'h0);
    repeat (40) @(negedge clk);
    rdReg(3, 1, 32'(11) << 10, "R9 zero limit free-runs");
    seen = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (irqCpu[3]) seen = 1'b1;
    end
    chk("R9 zero limit raises no interrupt", {31'd0, seen}, 32'd0);

    // configuration and unused words
    wrReg(SYS, 4, 32'hFFFF_FFFF);
    rdReg(SYS, 4, 32'h0000_000F, "R11 config low bits only");
    wrReg(SYS, 3, 32'hFFFF_FFFF);
    rdReg(SYS, 3, 32'h0, "R11 reserved word reads 0");
    wrReg(0, 4, 32'hFFFF_FFFF);
    rdReg(0, 4, 32'h0, "R11 processor offset 4 reads 0");
    wrReg(5, 0, 32'hFFFF_FFFF);
    rdReg(5, 0, 32'h0, "R11 unused index reads 0");
    rdReg(SYS, 4, 32'h0000_000F, "R11 config kept after other writes");

    repeat (3) @(negedge clk);
    chk("R12 every read answered", 32'(expQ.size()), 32'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule